// File: doc/BRIEF.md
# Debounced Two-Digit Key History

This block keeps the two most recent accepted digits typed on a keypad. A keypad scanner upstream supplies a 4-bit key code, a level that is high while a key is down, and a single-cycle strobe at the start of each press. The block counts how long the key stays down. A press is accepted only after the key has stayed down for more than `HOLD_CYCLES` consecutive clock edges. This rejects contact bounce and brief touches.

Each accepted press shifts the history once. The older digit takes the value of the newer digit, and the newer digit takes the key code that was captured when the strobe fired. Holding the key longer never causes a second shift. The two 4-bit digits drive a display multiplexer directly. Key decoding and display encoding happen elsewhere.

Top module: `key_history`

## Requirements
- R1: While `rst_ni` is low, and right after it rises, both `digit_new_o` and `digit_old_o` read 4'h0.
- R2: If the key stays down for at least `HOLD_CYCLES`+1 consecutive rising edges, starting with the edge that samples `press_en_i` high, the press is accepted. The new digit appears on `digit_new_o` after the next edge, which is edge `HOLD_CYCLES`+2 counted from the strobe edge.
- R3: If the key is down for `HOLD_CYCLES` edges or fewer before it is released, neither output changes.
- R4: An accepted press shifts the history exactly once, however long the key is then held.
- R5: On a shift, `digit_old_o` takes the value `digit_new_o` had just before the shift.
- R6: The value shifted in is `key_code_i` as sampled on the strobe edge. Later changes of `key_code_i` during the same press have no effect.
- R7: If the key is held without a strobe, no shift occurs, whatever the hold length.
- R8: A release cancels the pending press. After re-pressing without a new strobe, no shift occurs.
- R9: The threshold `HOLD_CYCLES` is a parameter with default 50. The hold counter saturates at `HOLD_CYCLES`+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| key_code_i | input | 4 | Hex code of the key being pressed |
| key_down_i | input | 1 | High while a key is held |
| press_en_i | input | 1 | Single-cycle strobe marking a new press |
| digit_new_o | output | 4 | Most recently accepted digit |
| digit_old_o | output | 4 | Digit accepted before the newest one |

## Verification
The presses are held for exactly `HOLD_CYCLES` and exactly `HOLD_CYCLES`+1 edges. Together these two cases pin the acceptance boundary to one cycle. A hold six times longer than the threshold shows whether a held key shifts only once. A code that changes after the strobe shows whether the captured value or the live input is shifted in. Holds without a strobe, and re-presses after a cancelled press, show that only strobe-armed presses can shift.

// File: rtl/key_history_pkg.sv
package key_history_pkg;
  localparam int unsigned DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/kh_hold_timer.sv
module kh_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic key_down_i,
  output logic held_o
);
  localparam int unsigned LIMIT = HOLD_CYCLES + 1;
  localparam int unsigned CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (!key_down_i)            cnt_q <= '0;
    else if (cnt_q < CNT_W'(LIMIT))  cnt_q <= cnt_q + 1'b1;
  end

  assign held_o = (cnt_q == CNT_W'(LIMIT));

  // R9 counter saturates
  a_r9_cnt_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(LIMIT));
  a_r3_release_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_down_i |=> !held_o);
endmodule

// File: rtl/kh_press_arm.sv
module kh_press_arm
  import key_history_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   key_down_i,
  input  logic   press_en_i,
  input  digit_t key_code_i,
  input  logic   held_i,
  output logic   shift_o,
  output digit_t code_o
);
  logic   pend_q;
  digit_t code_q;

  assign shift_o = pend_q & held_i;
  assign code_o  = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    pend_q <= 1'b0;
    else if (!key_down_i)           pend_q <= 1'b0;
    else if (press_en_i)            pend_q <= 1'b1;
    else if (shift_o)               pend_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        code_q <= '0;
    else if (press_en_i && key_down_i)  code_q <= key_code_i;
  end

  a_r4_one_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o && !press_en_i) |=> !shift_o);
  a_r8_release_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !key_down_i |=> !pend_q);
  a_r6_code_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !press_en_i |=> $stable(code_q));
endmodule

// File: rtl/kh_digit_shift.sv
module kh_digit_shift
  import key_history_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   shift_i,
  input  digit_t code_i,
  output digit_t digits_o [DEPTH]
);
  digit_t stage_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    digit_t src;
    if (g == 0) begin : g_head
      assign src = code_i;
    end else begin : g_tail
      assign src = stage_q[g-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      stage_q[g] <= '0;
      else if (shift_i) stage_q[g] <= src;
    end
    assign digits_o[g] = stage_q[g];

    a_r3_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !shift_i |=> $stable(stage_q[g]));
  end

  if (DEPTH > 1) begin : g_chk
    a_r5_age_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_i |=> stage_q[1] == $past(stage_q[0]));
  end
endmodule

// File: rtl/key_history.sv
module key_history
  import key_history_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [3:0] key_code_i,
  input  logic       key_down_i,
  input  logic       press_en_i,
  output logic [3:0] digit_new_o,
  output logic [3:0] digit_old_o
);
  localparam int unsigned DEPTH = 2;

  logic   held;
  logic   shift;
  digit_t code;
  digit_t digits [DEPTH];

  kh_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
    .clk_i, .rst_ni, .key_down_i, .held_o(held)
  );

  kh_press_arm u_arm (
    .clk_i, .rst_ni, .key_down_i, .press_en_i,
    .key_code_i(key_code_i), .held_i(held), .shift_o(shift), .code_o(code)
  );

  kh_digit_shift #(.DEPTH(DEPTH)) u_shift (
    .clk_i, .rst_ni, .shift_i(shift), .code_i(code), .digits_o(digits)
  );

  assign digit_new_o = digits[0];
  assign digit_old_o = digits[1];

  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (digit_new_o == '0 && digit_old_o == '0));
  a_r7_no_shift_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!key_down_i || !press_en_i) && !shift |=> $stable(digit_new_o));
endmodule

// File: tb/key_history_bench.sv
module key_history_bench;
  localparam int TH = 50;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [3:0] key_code_i = '0;
  logic key_down_i = 1'b0;
  logic press_en_i = 1'b0;
  logic [3:0] digit_new_o, digit_old_o;

  int n_chk = 0;
  int n_bad = 0;

  int m_cnt = 0, m_pend = 0, m_lat = 0, m_new = 0, m_old = 0;

  always #4 clk_i = ~clk_i;

  key_history #(.HOLD_CYCLES(TH)) u_key_history (.*);

  // behavioural reference
  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_cnt = 0; m_pend = 0; m_lat = 0; m_new = 0; m_old = 0;
    end else begin
      bit sh;
      sh = (m_pend != 0) && (m_cnt > TH);
      if (sh) begin m_old = m_new; m_new = m_lat; end
      if (!key_down_i) begin
        m_cnt = 0; m_pend = 0;
      end else begin
        if (m_cnt <= TH) m_cnt++;
        if (press_en_i) begin m_pend = 1; m_lat = key_code_i; end
        else if (sh) m_pend = 0;
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      n_chk++;
      if (digit_new_o != m_new[3:0] || digit_old_o != m_old[3:0]) begin
        n_bad++;
        $display("FAIL model R2/R5: new=%h old=%h exp new=%h old=%h",
                 digit_new_o, digit_old_o, m_new[3:0], m_old[3:0]);
      end
    end
  end

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic press(logic [3:0] code, logic [3:0] later, int edges, bit strobe);
    @(negedge clk_i);
    key_down_i = 1'b1; press_en_i = strobe; key_code_i = code;
    @(negedge clk_i);
    press_en_i = 1'b0; key_code_i = later;
    repeat (edges - 1) @(negedge clk_i);
    key_down_i = 1'b0;
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1 new in reset", digit_new_o, 4'h0);
    check("R1 old in reset", digit_old_o, 4'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 new after reset", digit_new_o, 4'h0);

    press(4'h3, 4'h3, TH + 10, 1'b1);
    check("R2 new", digit_new_o, 4'h3);
    check("R5 old", digit_old_o, 4'h0);

    press(4'h7, 4'h7, TH, 1'b1);
    check("R3 new unchanged", digit_new_o, 4'h3);
    check("R3 old unchanged", digit_old_o, 4'h0);

    press(4'h7, 4'h7, TH + 1, 1'b1);
    check("R2 boundary new", digit_new_o, 4'h7);
    check("R5 old takes prior", digit_old_o, 4'h3);

    press(4'hA, 4'hA, 6 * TH, 1'b1);
    check("R4 long hold new", digit_new_o, 4'hA);
    check("R4 long hold old", digit_old_o, 4'h7);

    press(4'h2, 4'h2, 2 * TH, 1'b0);
    check("R7 no strobe new", digit_new_o, 4'hA);
    check("R7 no strobe old", digit_old_o, 4'h7);

    press(4'hC, 4'hC, TH / 2, 1'b1);
    press(4'hC, 4'hC, 2 * TH, 1'b0);
    check("R8 cancelled new", digit_new_o, 4'hA);
    check("R8 cancelled old", digit_old_o, 4'h7);

    press(4'h5, 4'h9, TH + 5, 1'b1);
    check("R6 captured code", digit_new_o, 4'h5);
    check("R6 old", digit_old_o, 4'hA);

    press(4'hF, 4'hF, TH + 1, 1'b1);
    check("R9 default threshold new", digit_new_o, 4'hF);
    check("R9 default threshold old", digit_old_o, 4'h5);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule